// File: doc/BRIEF.md
# Dataflow Operand Matching Table

This block keeps the input operands waiting for the instructions that sit in one processing element, and it decides when each of those instructions may fire. Each instruction has a slot, two inputs (a left side and a right side), and its own current wave number. An operand arrives with a slot, a side, a wave number and a data word. Its wave number is taken relative to the slot's current wave. That offset picks a position in a small circular queue for each side. No stored tags are searched. A separate array of full/empty bits records which queue positions hold a value. The matching logic reads those bits to accept or refuse each arrival, and to find slots whose current wave has both operands.

When some slot has both operands for its current wave, the block offers a fire request. The request carries the slot, the wave and the two operands. A round-robin arbiter chooses one slot per cycle. An offered request stays fixed until the consumer takes it. When the request is taken, the entry is freed and the slot moves on to the next wave. An operand that arrives for a wave already stored in the window therefore becomes eligible at once. Operands that would land too far ahead, or on an occupied position, are refused through `opd_ready`. The sender keeps them.

Top module: `omt_match_table`

## Requirements
- R1: After reset, every slot's current wave is 0 and no entry is full. `fire_valid` is low, and `opd_ready` is high for any slot and either side (`opd_side` 0 = left, 1 = right) with wave 0 or 1.
- R2: An operand is refused (`opd_ready` low) and changes no state when its wave minus the slot's current wave, taken modulo 2^WAVE_W, is DEPTH (2) or more. This also covers waves behind the current one.
- R3: When both sides of a slot's current-wave entry are held, `fire_valid` is high. `fire_slot` and `fire_wave` then name that slot and wave, and `fire_left` and `fire_right` carry the stored left and right operands.
- R4: An operand for a side and position that is already full is refused. The stored value is never overwritten.
- R5: A taken fire (`fire_valid` and `fire_ready` both high) clears that entry and advances the slot's current wave by one. A later wave that was already fully stored then fires without any new arrival.
- R6: When no offer is being held, the granted slot is the first ready slot counting upward, with wrap, from the slot after the last one taken. The count starts from slot 0 after reset.
- R7: An offer that is not taken (`fire_ready` low) is presented again in the next cycle with the same slot, wave and operands, even if other slots have become ready.
- R8: At most one slot fires per cycle, and never a slot whose current-wave entry lacks an operand.
- R9: Wave numbers wrap modulo 2^WAVE_W. After wave 2^WAVE_W−1 a slot's current wave is 0, and the window check continues across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opd_valid | input | 1 | An operand is offered |
| opd_ready | output | 1 | The offered operand is accepted this cycle |
| opd_slot | input | SLOT_W (3) | Instruction slot of the operand |
| opd_side | input | 1 | Input side: 0 left, 1 right |
| opd_wave | input | WAVE_W (8) | Wave number of the operand |
| opd_data | input | DATA_W (32) | Operand value |
| fire_valid | output | 1 | A slot has both operands for its current wave |
| fire_ready | input | 1 | Consumer takes the offered fire |
| fire_slot | output | SLOT_W (3) | Slot being fired |
| fire_wave | output | WAVE_W (8) | Wave being fired |
| fire_left | output | DATA_W (32) | Left operand |
| fire_right | output | DATA_W (32) | Right operand |

## Verification
Directed sequences come first. A duplicate arrival on an occupied side shows whether a write was allowed to land on a full bit (R4). Arrivals two waves ahead and one wave behind test the modular window compare. An early-wave pair stored before the current wave tests that firing advances the slot and fires the next wave (R5). Several slots made ready while `fire_ready` is held low separate the held grant from the round-robin choice (R6, R7). A run of 260 consecutive waves on one slot crosses the wave-number wrap (R9). A seeded random phase then mixes near and far waves, both sides, and a throttled consumer, to expose interactions among these rules.

// File: rtl/omt_pkg.sv
package omt_pkg;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } omt_side_e;

  // Distance from the current wave to an operand's wave, modulo 2^width.
  function automatic int unsigned wave_gap(input logic [31:0] wave,
                                           input logic [31:0] cur,
                                           input int unsigned width);
    logic [31:0] diff;
    diff = wave - cur;
    if (width < 32) diff = diff & ((32'd1 << width) - 32'd1);
    return diff;
  endfunction

endpackage

// File: rtl/omt_presence.sv
module omt_presence #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic               set_side,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [ENTRIES-1:0] full_left,
  output logic [ENTRIES-1:0] full_right
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_bit
    logic hit_set;
    logic hit_clr;
    assign hit_set = set_en && (set_idx == IDX_W'(e));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_left[e]  <= 1'b0;
        full_right[e] <= 1'b0;
      end else if (hit_clr) begin
        full_left[e]  <= 1'b0;
        full_right[e] <= 1'b0;
      end else if (hit_set) begin
        if (set_side) full_right[e] <= 1'b1;
        else          full_left[e]  <= 1'b1;
      end
    end
  end

  // R4: a write never lands on a side that is already full
  assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !(set_side ? full_right[set_idx] : full_left[set_idx]));

  // R8: only a complete entry is ever released
  assert_clear_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> (full_left[clr_idx] && full_right[clr_idx]));

  // R5: an arrival and a release never address the same entry together
  assert_set_clear_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && clr_en) |-> (set_idx != clr_idx));

endmodule

// File: rtl/omt_operand_store.sv
module omt_operand_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/omt_rr_arbiter.sv
module omt_rr_arbiter #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             out_ready,
  output logic             grant_any,
  output logic [IDX_W-1:0] grant_idx,
  output logic [N-1:0]     grant_vec
);

  logic [IDX_W-1:0] rr_q;
  logic             hold_q;
  logic [IDX_W-1:0] hold_idx_q;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             take;

  function automatic logic [IDX_W-1:0] after(input logic [IDX_W-1:0] idx);
    return (int'(idx) == N - 1) ? '0 : IDX_W'(int'(idx) + 1);
  endfunction

  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = int'(rr_q) + k;
      if (c >= N) c = c - N;
      if (!pick_any && req[c]) begin
        pick_any = 1'b1;
        pick_idx = IDX_W'(c);
      end
    end
  end

  assign grant_any = hold_q || pick_any;
  assign grant_idx = hold_q ? hold_idx_q : pick_idx;
  assign grant_vec = grant_any ? (N'(1) << grant_idx) : '0;
  assign take      = grant_any && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q       <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else if (take) begin
      rr_q   <= after(grant_idx);
      hold_q <= 1'b0;
    end else if (grant_any) begin
      hold_q     <= 1'b1;
      hold_idx_q <= grant_idx;
    end
  end

  // R8: one grant at most
  assert_single_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  // R8: a grant always belongs to a requesting slot
  assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |-> req[grant_idx]);

  // R7: a refused offer is repeated unchanged
  assert_hold_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_any && !out_ready) |=> (grant_any && grant_idx == $past(grant_idx)));

endmodule

// File: rtl/omt_match_table.sv
module omt_match_table #(
  parameter int SLOTS  = 8,
  parameter int DEPTH  = 2,
  parameter int DATA_W = 32,
  parameter int WAVE_W = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opd_valid,
  output logic              opd_ready,
  input  logic [SLOT_W-1:0] opd_slot,
  input  logic              opd_side,
  input  logic [WAVE_W-1:0] opd_wave,
  input  logic [DATA_W-1:0] opd_data,
  output logic              fire_valid,
  input  logic              fire_ready,
  output logic [SLOT_W-1:0] fire_slot,
  output logic [WAVE_W-1:0] fire_wave,
  output logic [DATA_W-1:0] fire_left,
  output logic [DATA_W-1:0] fire_right
);
  import omt_pkg::*;

  localparam int POS_W   = $clog2(DEPTH);
  localparam int IDX_W   = SLOT_W + POS_W;
  localparam int ENTRIES = SLOTS * DEPTH;

  // Queue position of a wave inside a slot's circular window.
  function automatic logic [IDX_W-1:0] entry_of(input logic [SLOT_W-1:0] slot,
                                                input logic [WAVE_W-1:0] wave);
    return {slot, wave[POS_W-1:0]};
  endfunction

  logic [WAVE_W-1:0]  cur_wave_q [SLOTS];
  logic [ENTRIES-1:0] full_left;
  logic [ENTRIES-1:0] full_right;
  logic [SLOTS-1:0]   slot_ready;
  logic [SLOTS-1:0]   grant_vec;
  logic               grant_any;
  logic [SLOT_W-1:0]  grant_idx;

  // Arrival side
  logic [IDX_W-1:0]   arr_idx;
  logic               in_window;
  logic               arr_full;
  logic               arr_take;

  assign arr_idx   = entry_of(opd_slot, opd_wave);
  assign in_window = wave_gap(32'(opd_wave), 32'(cur_wave_q[opd_slot]), WAVE_W) < DEPTH;
  assign arr_full  = (opd_side == SIDE_RIGHT) ? full_right[arr_idx] : full_left[arr_idx];
  assign opd_ready = in_window && !arr_full;
  assign arr_take  = opd_valid && opd_ready;

  // Readiness of each slot's current wave
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [IDX_W-1:0] cur_idx;
    assign cur_idx       = entry_of(SLOT_W'(s), cur_wave_q[s]);
    assign slot_ready[s] = full_left[cur_idx] && full_right[cur_idx];
  end

  // Fire side
  logic [IDX_W-1:0] fire_idx;
  logic             fire_take;

  assign fire_valid = grant_any;
  assign fire_slot  = grant_idx;
  assign fire_wave  = cur_wave_q[grant_idx];
  assign fire_idx   = entry_of(grant_idx, fire_wave);
  assign fire_take  = fire_valid && fire_ready;

  omt_presence #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_presence (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (arr_take),
    .set_side   (opd_side),
    .set_idx    (arr_idx),
    .clr_en     (fire_take),
    .clr_idx    (fire_idx),
    .full_left  (full_left),
    .full_right (full_right)
  );

  logic [DATA_W-1:0] side_data [2];

  for (genvar sd = 0; sd < 2; sd++) begin : g_store
    omt_operand_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .wr_en   (arr_take && (opd_side == 1'(sd))),
      .wr_idx  (arr_idx),
      .wr_data (opd_data),
      .rd_idx  (fire_idx),
      .rd_data (side_data[sd])
    );
  end

  assign fire_left  = side_data[0];
  assign fire_right = side_data[1];

  omt_rr_arbiter #(.N(SLOTS), .IDX_W(SLOT_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (slot_ready),
    .out_ready (fire_ready),
    .grant_any (grant_any),
    .grant_idx (grant_idx),
    .grant_vec (grant_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) cur_wave_q[s] <= '0;
    end else if (fire_take) begin
      cur_wave_q[grant_idx] <= cur_wave_q[grant_idx] + 1'b1;
    end
  end

  // R2, R4: a refused arrival with no release leaves the bit array unchanged
  assert_refused_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (opd_valid && !opd_ready && !fire_take) |=> ($stable(full_left) && $stable(full_right)));

  // R5, R9: a taken fire advances that slot by exactly one wave, with wrap
  assert_wave_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_take |=> (cur_wave_q[$past(fire_slot)] == WAVE_W'($past(fire_wave) + 1'b1)));

  // R5: the released entry is empty in the following cycle
  assert_entry_freed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_take |=> (!full_left[$past(fire_idx)] && !full_right[$past(fire_idx)]));

  // R8: the grant vector agrees with the reported slot
  assert_grant_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid |-> (grant_vec[fire_slot] && slot_ready[fire_slot]));

endmodule

// File: tb/sim_omt_match_table.sv
`timescale 1ns/1ps
module sim_omt_match_table;
  localparam int SLOTS  = 8;
  localparam int DEPTH  = 2;
  localparam int DATA_W = 32;
  localparam int WAVE_W = 8;
  localparam int SLOT_W = $clog2(SLOTS);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              opd_valid;
  logic              opd_ready;
  logic [SLOT_W-1:0] opd_slot;
  logic              opd_side;
  logic [WAVE_W-1:0] opd_wave;
  logic [DATA_W-1:0] opd_data;
  logic              fire_valid;
  logic              fire_ready;
  logic [SLOT_W-1:0] fire_slot;
  logic [WAVE_W-1:0] fire_wave;
  logic [DATA_W-1:0] fire_left;
  logic [DATA_W-1:0] fire_right;

  always #2.5 clk = ~clk;

  omt_match_table #(.SLOTS(SLOTS), .DEPTH(DEPTH), .DATA_W(DATA_W), .WAVE_W(WAVE_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .opd_valid(opd_valid), .opd_ready(opd_ready), .opd_slot(opd_slot),
    .opd_side(opd_side), .opd_wave(opd_wave), .opd_data(opd_data),
    .fire_valid(fire_valid), .fire_ready(fire_ready), .fire_slot(fire_slot),
    .fire_wave(fire_wave), .fire_left(fire_left), .fire_right(fire_right)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string wave_tag = "R5";

  // Reference model state
  bit                m_full [2][SLOTS][DEPTH];
  logic [DATA_W-1:0] m_data [2][SLOTS][DEPTH];
  logic [WAVE_W-1:0] m_cur  [SLOTS];
  int                m_rr;
  bit                m_hold;
  int                m_hold_slot;

  function automatic int gap_of(int s, logic [WAVE_W-1:0] w);
    logic [WAVE_W-1:0] g;
    g = w - m_cur[s];
    return int'(g);
  endfunction

  function automatic bit exp_accept(int s, int side, logic [WAVE_W-1:0] w);
    if (gap_of(s, w) >= DEPTH) return 1'b0;
    return !m_full[side][s][int'(w) % DEPTH];
  endfunction

  function automatic bit slot_complete(int s);
    int p;
    p = int'(m_cur[s]) % DEPTH;
    return m_full[0][s][p] && m_full[1][s][p];
  endfunction

  function automatic int exp_pick();
    if (m_hold) return m_hold_slot;
    for (int k = 0; k < SLOTS; k++) begin
      int s;
      s = (m_rr + k) % SLOTS;
      if (slot_complete(s)) return s;
    end
    return -1;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, int s, int side, logic [WAVE_W-1:0] w,
                      logic [DATA_W-1:0] d, bit fr);
    int  pick;
    bit  acc;
    string tag;
    @(negedge clk);
    opd_valid  = v;
    opd_slot   = SLOT_W'(s);
    opd_side   = side[0];
    opd_wave   = w;
    opd_data   = d;
    fire_ready = fr;
    #1;
    pick = exp_pick();
    acc  = v && exp_accept(s, side, w);
    if (v) begin
      if (gap_of(s, w) >= DEPTH)                   tag = "R2";
      else if (m_full[side][s][int'(w) % DEPTH])   tag = "R4";
      else                                         tag = "R1";
      check(tag, "opd_ready", 64'(opd_ready), 64'(acc));
    end
    check((pick >= 0) ? "R3" : "R8", "fire_valid", 64'(fire_valid), 64'(pick >= 0));
    if (pick >= 0) begin
      check(m_hold ? "R7" : "R6", "fire_slot", 64'(fire_slot), 64'(pick));
      check(wave_tag, "fire_wave", 64'(fire_wave), 64'(m_cur[pick]));
      check("R3", "fire_left", 64'(fire_left), 64'(m_data[0][pick][int'(m_cur[pick]) % DEPTH]));
      check("R3", "fire_right", 64'(fire_right), 64'(m_data[1][pick][int'(m_cur[pick]) % DEPTH]));
    end
    // advance the model to the state after this edge
    if (pick >= 0 && fr) begin
      m_full[0][pick][int'(m_cur[pick]) % DEPTH] = 1'b0;
      m_full[1][pick][int'(m_cur[pick]) % DEPTH] = 1'b0;
      m_cur[pick] = m_cur[pick] + 1'b1;
      m_rr   = (pick + 1) % SLOTS;
      m_hold = 1'b0;
    end else if (pick >= 0) begin
      m_hold      = 1'b1;
      m_hold_slot = pick;
    end
    if (acc) begin
      m_full[side][s][int'(w) % DEPTH] = 1'b1;
      m_data[side][s][int'(w) % DEPTH] = d;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A7B));
    rst_n = 1'b0;
    opd_valid = 1'b0; opd_slot = '0; opd_side = 1'b0;
    opd_wave = '0; opd_data = '0; fire_ready = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      m_cur[s] = '0;
      for (int p = 0; p < DEPTH; p++) begin
        m_full[0][s][p] = 1'b0; m_full[1][s][p] = 1'b0;
        m_data[0][s][p] = '0;   m_data[1][s][p] = '0;
      end
    end
    m_rr = 0; m_hold = 1'b0; m_hold_slot = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "fire_valid after reset", 64'(fire_valid), 64'(0));
    opd_valid = 1'b1; opd_slot = 3'd5; opd_side = 1'b1; opd_wave = 8'd1;
    #0.5;
    check("R1", "opd_ready wave 1 after reset", 64'(opd_ready), 64'(1));
    opd_wave = 8'd2;
    #0.5;
    check("R2", "opd_ready wave 2 after reset", 64'(opd_ready), 64'(0));

    // R4: second write to a full side is refused and the first value survives
    step(1, 2, 0, 8'd0, 32'hAAAA_0001, 0);
    step(1, 2, 0, 8'd0, 32'hBBBB_0002, 0);
    step(1, 2, 1, 8'd0, 32'hCCCC_0003, 0);
    step(0, 0, 0, 8'd0, 32'h0, 0);          // offer held (R7)
    step(0, 0, 0, 8'd0, 32'h0, 1);          // taken with A and C (R3, R4)
    step(0, 0, 0, 8'd0, 32'h0, 1);

    // R2: too far ahead and behind are refused; early wave stored, then fires after current (R5, R8)
    step(1, 4, 0, 8'd2,   32'h1111_0000, 1);
    step(1, 4, 0, 8'd255, 32'h2222_0000, 1);
    step(1, 4, 0, 8'd1,   32'h3333_0001, 1);
    step(1, 4, 1, 8'd1,   32'h4444_0001, 1);
    step(0, 0, 0, 8'd0,   32'h0, 1);        // wave 1 complete, wave 0 empty: no fire
    step(1, 4, 1, 8'd0,   32'h5555_0000, 1);
    step(1, 4, 0, 8'd0,   32'h6666_0000, 1);
    step(0, 0, 0, 8'd0,   32'h0, 1);        // wave 0 fires
    step(0, 0, 0, 8'd0,   32'h0, 1);        // wave 1 fires
    step(0, 0, 0, 8'd0,   32'h0, 1);

    // R6, R7: several slots ready while the consumer stalls
    step(1, 6, 0, 8'd0, 32'h6060_0000, 0);
    step(1, 6, 1, 8'd0, 32'h6161_0000, 0);
    step(1, 1, 0, 8'd0, 32'h1010_0000, 0);
    step(1, 1, 1, 8'd0, 32'h1111_0000, 0);
    step(1, 5, 0, 8'd0, 32'h5050_0000, 0);
    step(1, 5, 1, 8'd0, 32'h5151_0000, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 8'd0, 32'h0, 1);

    // R9: run one slot across the wave-number wrap
    wave_tag = "R9";
    for (int i = 0; i < 260; i++) begin
      logic [WAVE_W-1:0] w;
      w = WAVE_W'(i);
      step(1, 7, 0, w, 32'(i) ^ 32'h00F0_0000, 1);
      step(1, 7, 1, w, 32'(i) ^ 32'h0F00_0000, 1);
    end
    step(0, 0, 0, 8'd0, 32'h0, 1);
    step(1, 7, 0, 8'd6, 32'h0, 1);           // gap 2 after wrap: refused (R9, R2)
    wave_tag = "R5";

    // Seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      int s;
      int side;
      logic [WAVE_W-1:0] w;
      s    = int'($urandom % SLOTS);
      side = int'($urandom % 2);
      if ($urandom % 6 == 0) w = WAVE_W'($urandom);
      else                   w = m_cur[s] + WAVE_W'($urandom % DEPTH);
      step(($urandom % 5) != 0, s, side, w, $urandom, ($urandom % 4) != 0);
    end
    for (int i = 0; i < 20; i++) step(0, 0, 0, 8'd0, 32'h0, 1);

    done = 1;
    summary();
    $finish;
  end

endmodule